// File: doc/BRIEF.md
# Auto-Increment Byte ROM Bus Slave

This block is a read-only byte slave on a shared processor bus. The bus master does not present an address on every access. Instead it loads a 16-bit address counter inside the slave with two byte writes, then fetches data one byte per bus cycle. Each data read returns the byte at the counter and moves the counter on by one. A backing memory port behind the block supplies the bytes through a request/valid handshake.

The master controls the bus with three inputs:
- a select strobe;
- a read/write direction;
- a mode bit that chooses between the address register and the data path.

The slave answers on three outputs:
- an 8-bit read data bus with an output enable;
- an open-drain ready line;
- the backing memory port.

The ready line is pulled low (not ready) whenever the slave is idle. It is released only once the current operation has finished. Several slaves can share this line.

All slaves on the bus follow every address load. A slave drives data only for bytes inside its own address region. Loading the low address byte starts a prefetch of the new byte, so that cycle completes later than the others. A build option stops the slave from driving the bus on address reads, so that another device on the bus can report the address.

Top module: `autoinc_rom_slave`

## Requirements
- R1: After reset the ready pull output is 1 (not ready), the read data enable is 0 and no memory request is made. A data read before any address load completes with the enable held at 0.
- R2: Two address-mode writes load the counter, high byte first, then low byte. The following data read returns the backing byte at the loaded address.
- R3: Each data read returns the byte at the current counter and then advances the counter by one, so back-to-back reads return consecutive addresses.
- R4: A low-byte address write fetches the byte at the new address from the backing port before ready is given. That cycle lasts at least the memory latency longer than a high-byte address write.
- R5: The ready pull output is 1 while idle. It goes to 0 when an operation finishes, stays 0 while select is held, and returns to 1 after select is removed.
- R6: An address read returns the counter, high byte on the first read and low byte on the second. The value returned is the loaded address plus one plus the number of data reads since the load.
- R7: With ADDR_RD_EN = 0 an address read completes with ready but never asserts the read data enable. Data reads are unaffected.
- R8: Data is driven only for a byte whose address has bits [15:13] equal to REGION_ID (default 1, that is 0x2000 to 0x3FFF). Outside the region the cycle still completes with ready and the counter still advances, including across 0x3FFF to 0x4000 and from 0xFFFF to 0x0000.
- R9: A data write completes with ready and changes neither the counter nor the next byte returned.
- R10: The read data enable falls in the same moment that select falls, and it is never 1 while select is 0.
- R11: Any data access (read or write) resets the address byte pointer, so the next address write is taken as the high byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| sel_i | input | 1 | Bus select strobe, active high |
| read_i | input | 1 | 1 = read cycle, 0 = write cycle |
| addr_mode_i | input | 1 | 1 = address register access, 0 = data access |
| wdata_i | input | 8 | Write data from the master |
| rdata_o | output | 8 | Read data to the master |
| rdata_oe_o | output | 1 | Enable for driving rdata_o onto the bus |
| rdy_pull_o | output | 1 | 1 = pull the shared ready line low (not ready) |
| mem_req_o | output | 1 | Backing memory fetch request, held until valid |
| mem_addr_o | output | 16 | Backing memory fetch address |
| mem_valid_i | input | 1 | Backing memory data valid, one-cycle pulse |
| mem_rdata_i | input | 8 | Backing memory read data |

## Verification
The hardest situation to reach is the data-read prefetch. It runs only after select has been released, so it overlaps the gap before the next bus cycle. Its effect shows up only in the byte and the enable returned by the following read.

The bench tracks the counter and the buffered byte address in a behavioural model. It issues chains of reads that run across the region edge at 0x3FFF and across the counter wrap at 0xFFFF. After a data write and after a lone high-byte write it reads the counter back, which exposes any stray advance and any stale byte pointer.

// File: rtl/autoinc_rom_pkg.sv
package autoinc_rom_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_FETCH = 2'd1,
        ST_HOLD  = 2'd2
    } slv_state_e;
endpackage

// File: rtl/autoinc_sync.sv
module autoinc_sync #(
    parameter int W = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);
    logic [W-1:0] s1_q, s2_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s1_q <= '0;
            s2_q <= '0;
        end else begin
            s1_q <= d_i;
            s2_q <= s1_q;
        end
    end

    assign q_o = s2_q;
endmodule

// File: rtl/autoinc_core.sv
module autoinc_core
    import autoinc_rom_pkg::*;
#(
    parameter int              AW          = 16,
    parameter int              DW          = 8,
    parameter int              RB          = 3,
    parameter logic [RB-1:0]   REGION_ID   = 3'd1,
    parameter bit              ADDR_RD_EN  = 1'b1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          sel_s,
    input  logic          rd_s,
    input  logic          amode_s,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] dout,
    output logic          oe_q,
    output logic          rdy_pull,
    output logic          mem_req,
    output logic [AW-1:0] mem_addr,
    input  logic          mem_valid,
    input  logic [DW-1:0] mem_rdata
);
    localparam int HI_LSB = AW - DW;

    typedef struct packed {
        slv_state_e    st;
        logic [AW-1:0] addr;
        logic [DW-1:0] pbuf;
        logic          hit;
        logic          lo_next;
        logic [DW-1:0] dout;
        logic          oe;
        logic          pend;
        logic          fin_hold;
    } core_t;

    core_t q, d;

    always_comb begin
        d = q;
        unique case (q.st)
            ST_IDLE: begin
                if (sel_s) begin
                    d.st   = ST_HOLD;
                    d.oe   = 1'b0;
                    d.pend = 1'b0;
                    if (amode_s) begin
                        if (rd_s) begin
                            d.dout    = q.lo_next ? q.addr[DW-1:0] : q.addr[AW-1:HI_LSB];
                            d.oe      = ADDR_RD_EN;
                            d.lo_next = !q.lo_next;
                        end else if (!q.lo_next) begin
                            d.addr[AW-1:HI_LSB] = wdata;
                            d.lo_next           = 1'b1;
                        end else begin
                            d.addr[DW-1:0] = wdata;
                            d.lo_next      = 1'b0;
                            d.st           = ST_FETCH;
                            d.fin_hold     = 1'b1;
                        end
                    end else begin
                        d.lo_next = 1'b0;
                        if (rd_s) begin
                            d.dout = q.pbuf;
                            d.oe   = q.hit;
                            d.pend = 1'b1;
                        end
                    end
                end
            end
            ST_FETCH: begin
                if (mem_valid) begin
                    d.pbuf     = mem_rdata;
                    d.hit      = (q.addr[AW-1 -: RB] == REGION_ID);
                    d.addr     = q.addr + AW'(1);
                    d.st       = q.fin_hold ? ST_HOLD : ST_IDLE;
                    d.fin_hold = 1'b0;
                end
            end
            ST_HOLD: begin
                if (!sel_s) begin
                    d.oe   = 1'b0;
                    d.st   = q.pend ? ST_FETCH : ST_IDLE;
                    d.pend = 1'b0;
                end
            end
            default: d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '{st: ST_IDLE, default: '0};
        end else begin
            q <= d;
        end
    end

    assign dout     = q.dout;
    assign oe_q     = q.oe;
    assign rdy_pull = (q.st != ST_HOLD);
    assign mem_req  = (q.st == ST_FETCH);
    assign mem_addr = q.addr;

    // R5: once ready is given it is kept while select stays high
    a_r5_ready_held: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == ST_HOLD && sel_s) |=> (q.st == ST_HOLD));

    // R4: a pending fetch keeps its request and address until data arrives
    a_r4_fetch_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == ST_FETCH && !mem_valid) |=> (q.st == ST_FETCH && $stable(q.addr)));

    // R3: every completed fetch steps the counter by exactly one
    a_r3_counter_step: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == ST_FETCH && mem_valid) |=> (q.addr == $past(q.addr) + AW'(1)));

    // R9: a data write leaves counter and buffered byte untouched
    a_r9_write_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == ST_IDLE && sel_s && !amode_s && !rd_s) |=> ($stable(q.addr) && $stable(q.pbuf)));
endmodule

// File: rtl/autoinc_rom_slave.sv
module autoinc_rom_slave #(
    parameter int            AW         = 16,
    parameter int            DW         = 8,
    parameter int            RB         = 3,
    parameter logic [RB-1:0] REGION_ID  = 3'd1,
    parameter bit            ADDR_RD_EN = 1'b1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          sel_i,
    input  logic          read_i,
    input  logic          addr_mode_i,
    input  logic [DW-1:0] wdata_i,
    output logic [DW-1:0] rdata_o,
    output logic          rdata_oe_o,
    output logic          rdy_pull_o,
    output logic          mem_req_o,
    output logic [AW-1:0] mem_addr_o,
    input  logic          mem_valid_i,
    input  logic [DW-1:0] mem_rdata_i
);
    logic [2:0] ctl_s;
    logic       oe_q;

    autoinc_sync #(.W(3)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   ({sel_i, read_i, addr_mode_i}),
        .q_o   (ctl_s)
    );

    autoinc_core #(
        .AW(AW), .DW(DW), .RB(RB), .REGION_ID(REGION_ID), .ADDR_RD_EN(ADDR_RD_EN)
    ) u_core (
        .clk       (clk),
        .rst_n     (rst_n),
        .sel_s     (ctl_s[2]),
        .rd_s      (ctl_s[1]),
        .amode_s   (ctl_s[0]),
        .wdata     (wdata_i),
        .dout      (rdata_o),
        .oe_q      (oe_q),
        .rdy_pull  (rdy_pull_o),
        .mem_req   (mem_req_o),
        .mem_addr  (mem_addr_o),
        .mem_valid (mem_valid_i),
        .mem_rdata (mem_rdata_i)
    );

    assign rdata_oe_o = oe_q & sel_i;

    // R10: the bus is only driven during the ready phase of a cycle
    a_r10_oe_in_ready: assert property (@(posedge clk) disable iff (!rst_n)
        rdata_oe_o |-> !rdy_pull_o);
endmodule

// File: tb/tb_autoinc_rom_slave.sv
module tb_autoinc_rom_slave;
    localparam int MEM_LAT = 3;

    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic        rst_n = 1'b0, sel = 1'b0, rd = 1'b0, am = 1'b0;
    logic [7:0]  wd = 8'h00, mem_rdata = 8'h00;
    logic        mem_valid = 1'b0;
    logic [7:0]  rdata, rdata2;
    logic        oe_o, oe2_o, rdy_pull, rdy_pull2, mem_req, mem_req2;
    logic [15:0] mem_addr, mem_addr2;

    autoinc_rom_slave dut (
        .clk(clk), .rst_n(rst_n), .sel_i(sel), .read_i(rd), .addr_mode_i(am),
        .wdata_i(wd), .rdata_o(rdata), .rdata_oe_o(oe_o), .rdy_pull_o(rdy_pull),
        .mem_req_o(mem_req), .mem_addr_o(mem_addr),
        .mem_valid_i(mem_valid), .mem_rdata_i(mem_rdata)
    );

    autoinc_rom_slave #(.ADDR_RD_EN(1'b0)) dut_nard (
        .clk(clk), .rst_n(rst_n), .sel_i(sel), .read_i(rd), .addr_mode_i(am),
        .wdata_i(wd), .rdata_o(rdata2), .rdata_oe_o(oe2_o), .rdy_pull_o(rdy_pull2),
        .mem_req_o(mem_req2), .mem_addr_o(mem_addr2),
        .mem_valid_i(mem_valid), .mem_rdata_i(mem_rdata)
    );

    int  checks = 0, fails = 0;
    bit  done = 0;

    logic [15:0] r_addr = 16'h0, r_baddr = 16'h0;
    bit          r_bvalid = 0, r_lo = 0;

    function automatic logic [7:0] romf(input logic [15:0] a);
        return a[7:0] ^ a[15:8] ^ 8'h5A;
    endfunction

    function automatic bit inr(input logic [15:0] a);
        return a[15:13] == 3'd1;
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // backing memory with fixed latency
    initial begin
        int cnt = 0;
        forever begin
            @(negedge clk);
            if (mem_valid) mem_valid = 1'b0;
            else if (mem_req) begin
                cnt++;
                if (cnt >= MEM_LAT) begin
                    mem_valid = 1'b1;
                    mem_rdata = romf(mem_addr);
                    cnt = 0;
                end
            end else cnt = 0;
        end
    end

    // R10 monitor: enable never high while select is low
    initial begin
        forever begin
            @(posedge clk); #2;
            if (rst_n && !sel) chk("R10 enable while select low", {oe_o, oe2_o}, 0);
        end
    end

    task automatic bus(input bit r, input bit a, input logic [7:0] w,
                       output logic [7:0] dat, output bit oe, output bit oe2, output int lat);
        @(negedge clk);
        rd = r; am = a; wd = w; sel = 1'b1; lat = 0;
        do begin @(negedge clk); lat++; end while (rdy_pull && lat < 1000);
        chk("R5 ready reached", rdy_pull, 0);
        repeat (3) begin
            @(negedge clk);
            chk("R5 ready held while selected", rdy_pull, 0);
        end
        dat = rdata; oe = oe_o; oe2 = oe2_o;
        sel = 1'b0;
        #1;
        chk("R10 enable drops with select", {oe_o, oe2_o}, 0);
        while (!rdy_pull) @(negedge clk);
        chk("R5 not ready after release", rdy_pull, 1);
        repeat (8) @(negedge clk);
    endtask

    task automatic addr_wr(input logic [7:0] b, output int lat);
        logic [7:0] d; bit o, o2;
        bus(1'b0, 1'b1, b, d, o, o2, lat);
        if (!r_lo) begin
            r_addr[15:8] = b; r_lo = 1;
        end else begin
            r_addr[7:0] = b; r_lo = 0;
            r_baddr = r_addr; r_bvalid = 1; r_addr = r_addr + 16'd1;
        end
    endtask

    task automatic load(input logic [15:0] a);
        int l;
        addr_wr(a[15:8], l);
        addr_wr(a[7:0], l);
    endtask

    task automatic data_rd(input string tag);
        logic [7:0] d; bit o, o2; int l; bit exp_oe;
        bus(1'b1, 1'b0, 8'h00, d, o, o2, l);
        exp_oe = r_bvalid && inr(r_baddr);
        chk({tag, " enable"}, o, exp_oe);
        chk({tag, " R7 data enable unaffected"}, o2, exp_oe);
        if (exp_oe) chk({tag, " data"}, d, romf(r_baddr));
        r_baddr = r_addr; r_bvalid = 1; r_addr = r_addr + 16'd1; r_lo = 0;
    endtask

    task automatic data_wr(input logic [7:0] w);
        logic [7:0] d; bit o, o2; int l;
        bus(1'b0, 1'b0, w, d, o, o2, l);
        chk("R9 write not driven", o, 0);
        r_lo = 0;
    endtask

    task automatic addr_rd(input string tag);
        logic [7:0] d; bit o, o2; int l;
        bus(1'b1, 1'b1, 8'h00, d, o, o2, l);
        chk({tag, " counter byte"}, d, r_lo ? r_addr[7:0] : r_addr[15:8]);
        chk({tag, " enable"}, o, 1);
        chk("R7 address read not driven", o2, 0);
        r_lo = !r_lo;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        int lat_hi, lat_lo;
        repeat (3) @(negedge clk);
        chk("R1 reset ready pull", rdy_pull, 1);
        chk("R1 reset enable", oe_o, 0);
        chk("R1 reset mem request", mem_req, 0);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);
        chk("R5 idle not ready", rdy_pull, 1);
        chk("R1 no request after reset", mem_req, 0);

        data_rd("R1 read before load");

        addr_wr(8'h20, lat_hi);
        addr_wr(8'h10, lat_lo);
        chk("R4 low byte cycle longer", (lat_lo >= lat_hi + MEM_LAT), 1);
        data_rd("R2 first byte");
        data_rd("R3 second byte");
        data_rd("R3 third byte");
        addr_rd("R6 high");
        addr_rd("R6 low");

        data_wr(8'hFF);
        addr_rd("R9 high after write");
        addr_rd("R9 low after write");
        data_rd("R9 read after write");

        load(16'h3FFE);
        data_rd("R8 3FFE");
        data_rd("R8 3FFF");
        data_rd("R8 4000 outside");
        addr_rd("R8 counter high");
        addr_rd("R8 counter low");

        load(16'hFFFF);
        data_rd("R8 FFFF outside");
        data_rd("R8 0000 outside");
        addr_rd("R8 wrap high");
        addr_rd("R8 wrap low");

        addr_wr(8'h21, lat_hi);
        data_rd("R11 read after lone high byte");
        load(16'h2500);
        data_rd("R11 reload after data access");
        addr_rd("R11 counter high");
        data_wr(8'h00);
        load(16'h2A80);
        data_rd("R11 reload after data write");

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule